// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Atomic Set and Clear

This block gives a processor a bank of 8-bit general-purpose I/O ports through a simple word-addressed register bus with an address, write data, read data and separate read and write strobes. Every pin can be made an input or an output, can drive a written level, and has its current level readable. A per-port function-select register chooses which of several functions each pin serves. Ordinary GPIO is only one choice, and the select value is exported so that other logic can route alternate functions.

Each port has five registers. The data register packs direction, output level, the pin levels captured just after reset, and the live pin levels. Write-only set and clear registers change chosen output bits without a read-modify-write sequence, so software on several threads cannot lose an update. A pull-up register enables internal pull-ups, except on ports that have no pull-ups. Pin inputs pass through a two-flop synchronizer before anything can read them.

Top module: `gpio_bank`

## Requirements
- R1: While reset is high and on the first edge after it, every register is zero. pin_out, pin_oe, pin_pu, pin_fsel and bus_rdata are then all zero.
- R2: The function-select register of port p is at byte offset 4*p. It holds 2 bits per pin, with pin i at bits [2i+1:2i] and bits 31:16 reading as zero. It can be read back, and it drives pin_fsel[16p+2i+1:16p+2i].
- R3: A pin's output enable equals its direction bit when its function select is 0 (GPIO), and is 0 for any other select value.
- R4: The data register of port p is at offset 0x20+0x10*p. A write loads direction (1 = output) from bits 31:24 and the output level from bits 23:16, and pin_out shows the new level one edge after the write.
- R5: Data register bits 7:0 return the live pins after a two-flop synchronizer. A level present at two rising edges is returned by a read issued after the second edge. Writes to bits 15:0 are ignored.
- R6: Data register bits 15:8 return the synchronized pin levels that were present when reset was released. The capture happens on the third rising edge after reset falls, and the value does not change until the next reset.
- R7: The set register (offset 0x24+0x10*p) forces each output bit high whose bit in wdata[23:16] is 1. Bits written as 0 are unchanged, and a read returns zero.
- R8: The clear register (offset 0x28+0x10*p) forces each output bit low whose bit in wdata[23:16] is 1. Bits written as 0 are unchanged, and a read returns zero.
- R9: The pull-up register (offset 0x2C+0x10*p) holds pull-up enables in bits 7:0 and drives pin_pu. On ports 2 and 4, writes have no effect, reads return zero and pin_pu stays 0.
- R10: bus_rdata is registered. It carries the addressed value one edge after a read strobe and is zero after any cycle without one. Unaligned or unmapped addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 40 | Raw pin levels, port p at [8p+7:8p] |
| pin_out | output | 40 | Output levels to the pads |
| pin_oe | output | 40 | Output enables to the pads |
| pin_pu | output | 40 | Pull-up enables to the pads |
| pin_fsel | output | 80 | Function select per pin, 2 bits each |

## Verification
A register write reaches pin_out, pin_oe, pin_pu and pin_fsel on the edge that samples the write strobe, and read data appears on the edge that samples the read strobe. A live pin level reaches bits 7:0 only after two synchronizer edges, and the reset snapshot is taken on the third edge after reset falls. The bench model advances one step at every rising edge, computing read results from the state before that edge. All outputs are compared at every falling edge, so each result is checked in the cycle it is due and not later.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PIN_W      = 8;
    localparam int FSEL_W     = 2;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int PORT_IDX_W = 3;
    localparam int PORT_BASE  = 32;
    localparam int PORT_STRIDE = 16;

    localparam int DIR_LSB  = 24;
    localparam int OUT_LSB  = 16;
    localparam int SNAP_LSB = 8;
    localparam int LIVE_LSB = 0;

    localparam logic [FSEL_W-1:0] FSEL_GPIO = '0;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_SET  = 2'd1,
        KIND_CLR  = 2'd2,
        KIND_PULL = 2'd3
    } port_reg_e;

    typedef struct packed {
        logic                  hit_cfg;
        logic                  hit_port;
        logic [PORT_IDX_W-1:0] port;
        port_reg_e             kind;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int nports);
        dec_t d;
        int   off;
        d   = '0;
        off = int'(a) - PORT_BASE;
        if (a[1:0] == 2'b00) begin
            if (int'(a) < PORT_BASE) begin
                if (int'(a[4:2]) < nports) begin
                    d.hit_cfg = 1'b1;
                    d.port    = a[4:2];
                end
            end else if (off < PORT_STRIDE * nports) begin
                d.hit_port = 1'b1;
                d.port     = PORT_IDX_W'(off / PORT_STRIDE);
                d.kind     = port_reg_e'(a[3:2]);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_bank_pkg::*;
#(
    parameter int PW       = PIN_W,
    parameter int FW       = FSEL_W,
    parameter bit HAS_PULL = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               data_we,
    input  logic               set_we,
    input  logic               clr_we,
    input  logic               pull_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [PW-1:0]      pad_in,
    output logic [PW*FW-1:0]   fsel_q,
    output logic [PW-1:0]      dir_q,
    output logic [PW-1:0]      out_q,
    output logic [PW-1:0]      pull_q,
    output logic [PW-1:0]      oe,
    output logic [PW-1:0]      live,
    output logic [PW-1:0]      snap
);
    logic [PW-1:0] set_bits;
    logic [PW-1:0] clr_bits;
    logic [1:0]    snap_age;

    assign set_bits = set_we ? wdata[OUT_LSB +: PW] : '0;
    assign clr_bits = clr_we ? wdata[OUT_LSB +: PW] : '0;

    gpio_sync #(.W(PW)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pad_in),
        .d_sync  (live)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fsel_q <= '0;
        end else if (cfg_we) begin
            fsel_q <= wdata[PW*FW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
        end else if (data_we) begin
            dir_q <= wdata[DIR_LSB +: PW];
            out_q <= wdata[OUT_LSB +: PW];
        end else begin
            out_q <= (out_q | set_bits) & ~clr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_age <= '0;
            snap     <= '0;
        end else begin
            if (snap_age != 2'd3) snap_age <= snap_age + 2'd1;
            if (snap_age == 2'd2) snap <= live;
        end
    end

    generate
        if (HAS_PULL) begin : g_pull
            always_ff @(posedge clk) begin
                if (rst) begin
                    pull_q <= '0;
                end else if (pull_we) begin
                    pull_q <= wdata[PW-1:0];
                end
            end
        end else begin : g_nopull
            assign pull_q = '0;
        end
    endgenerate

    generate
        for (genvar i = 0; i < PW; i++) begin : g_oe
            assign oe[i] = dir_q[i] & (fsel_q[i*FW +: FW] == FSEL_GPIO);
        end
    endgenerate

    a_r7_set_forces_high: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((out_q & $past(wdata[OUT_LSB +: PW])) == $past(wdata[OUT_LSB +: PW])))
        else $error("set register did not raise bits");

    a_r8_clr_forces_low: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((out_q & $past(wdata[OUT_LSB +: PW])) == '0))
        else $error("clear register did not lower bits");

    a_r6_snapshot_frozen: assert property (@(posedge clk) disable iff (rst)
        (snap_age == 2'd3 && $past(snap_age) == 2'd3) |-> $stable(snap))
        else $error("reset snapshot changed");
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter logic [NUM_PORTS-1:0] NOPULL_MASK = 5'b10100,
    localparam int PINS = NUM_PORTS * PIN_W,
    localparam int FSEL_BITS = PIN_W * FSEL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [PINS-1:0]           pin_in,
    output logic [PINS-1:0]           pin_out,
    output logic [PINS-1:0]           pin_oe,
    output logic [PINS-1:0]           pin_pu,
    output logic [NUM_PORTS*FSEL_BITS-1:0] pin_fsel
);
    dec_t dec;
    logic [DATA_W-1:0] rd_mux;

    logic [FSEL_BITS-1:0] fsel_v [NUM_PORTS];
    logic [PIN_W-1:0]     dir_v  [NUM_PORTS];
    logic [PIN_W-1:0]     out_v  [NUM_PORTS];
    logic [PIN_W-1:0]     pull_v [NUM_PORTS];
    logic [PIN_W-1:0]     live_v [NUM_PORTS];
    logic [PIN_W-1:0]     snap_v [NUM_PORTS];

    assign dec = decode_addr(bus_addr, NUM_PORTS);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic sel;
            assign sel = bus_wr && (dec.port == PORT_IDX_W'(p));

            gpio_port #(
                .PW       (PIN_W),
                .FW       (FSEL_W),
                .HAS_PULL (!NOPULL_MASK[p])
            ) u_port (
                .clk     (clk),
                .rst     (rst),
                .cfg_we  (sel && dec.hit_cfg),
                .data_we (sel && dec.hit_port && dec.kind == KIND_DATA),
                .set_we  (sel && dec.hit_port && dec.kind == KIND_SET),
                .clr_we  (sel && dec.hit_port && dec.kind == KIND_CLR),
                .pull_we (sel && dec.hit_port && dec.kind == KIND_PULL),
                .wdata   (bus_wdata),
                .pad_in  (pin_in[p*PIN_W +: PIN_W]),
                .fsel_q  (fsel_v[p]),
                .dir_q   (dir_v[p]),
                .out_q   (out_v[p]),
                .pull_q  (pull_v[p]),
                .oe      (pin_oe[p*PIN_W +: PIN_W]),
                .live    (live_v[p]),
                .snap    (snap_v[p])
            );

            assign pin_out[p*PIN_W +: PIN_W]          = out_v[p];
            assign pin_pu[p*PIN_W +: PIN_W]           = pull_v[p];
            assign pin_fsel[p*FSEL_BITS +: FSEL_BITS] = fsel_v[p];

            for (genvar i = 0; i < PIN_W; i++) begin : g_chk
                a_r3_oe_only_gpio: assert property (@(posedge clk) disable iff (rst)
                    pin_oe[p*PIN_W+i] |-> (pin_fsel[(p*PIN_W+i)*FSEL_W +: FSEL_W] == FSEL_GPIO))
                    else $error("output enabled on a non-GPIO pin");
            end
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (dec.port == PORT_IDX_W'(p)) begin
                if (dec.hit_cfg) begin
                    rd_mux = DATA_W'(fsel_v[p]);
                end else if (dec.hit_port) begin
                    case (dec.kind)
                        KIND_DATA: rd_mux = {dir_v[p], out_v[p], snap_v[p], live_v[p]};
                        KIND_PULL: rd_mux = DATA_W'(pull_v[p]);
                        default:   rd_mux = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? rd_mux : '0;
        end
    end

    a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0))
        else $error("read data not zero after idle cycle");
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
    localparam int NP = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [39:0] pin_in = 40'h5A_C3_0F_81_A5;
    logic [39:0] pin_out;
    logic [39:0] pin_oe;
    logic [39:0] pin_pu;
    logic [79:0] pin_fsel;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;

    always #4 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_pu    (pin_pu),
        .pin_fsel  (pin_fsel)
    );

    // behavioural reference state
    logic [15:0] m_cfg  [NP];
    logic [7:0]  m_dir  [NP];
    logic [7:0]  m_out  [NP];
    logic [7:0]  m_pull [NP];
    logic [7:0]  m_snap [NP];
    logic [39:0] m_pins_d1, m_pins_d2;
    int          m_edges;
    logic [31:0] m_rd;
    string       m_rd_tag = "R1";

    function automatic bit has_pull(input int p);
        return !(p == 2 || p == 4);
    endfunction

    task automatic model_read(input logic [7:0] a, output logic [31:0] v, output string tag);
        int p;
        v = '0;
        tag = "R10";
        if (a[1:0] != 2'b00) return;
        if (a < 8'h20) begin
            p = int'(a) / 4;
            if (p < NP) begin v = {16'h0, m_cfg[p]}; tag = "R2"; end
        end else if (a < 8'h20 + 8'(16*NP)) begin
            p = (int'(a) - 32) / 16;
            case ((int'(a) / 4) % 4)
                0: begin v = {m_dir[p], m_out[p], m_snap[p], m_pins_d2[p*8 +: 8]}; tag = "R4 R5 R6"; end
                1: begin v = '0; tag = "R7"; end
                2: begin v = '0; tag = "R8"; end
                default: begin v = has_pull(p) ? {24'h0, m_pull[p]} : '0; tag = "R9"; end
            endcase
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int p;
        if (a[1:0] != 2'b00) return;
        if (a < 8'h20) begin
            p = int'(a) / 4;
            if (p < NP) m_cfg[p] = d[15:0];
        end else if (a < 8'h20 + 8'(16*NP)) begin
            p = (int'(a) - 32) / 16;
            case ((int'(a) / 4) % 4)
                0: begin m_dir[p] = d[31:24]; m_out[p] = d[23:16]; end
                1: m_out[p] = m_out[p] | d[23:16];
                2: m_out[p] = m_out[p] & ~d[23:16];
                default: if (has_pull(p)) m_pull[p] = d[7:0];
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NP; p++) begin
                m_cfg[p] = '0; m_dir[p] = '0; m_out[p] = '0; m_pull[p] = '0; m_snap[p] = '0;
            end
            m_pins_d1 = '0; m_pins_d2 = '0; m_edges = 0; m_rd = '0; m_rd_tag = "R1";
        end else begin
            if (bus_rd) model_read(bus_addr, m_rd, m_rd_tag);
            else begin m_rd = '0; m_rd_tag = "R10"; end
            if (m_edges == 2)
                for (int p = 0; p < NP; p++) m_snap[p] = m_pins_d2[p*8 +: 8];
            if (m_edges < 3) m_edges++;
            if (bus_wr) model_write(bus_addr, bus_wdata);
            m_pins_d2 = m_pins_d1;
            m_pins_d1 = pin_in;
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            logic [39:0] e_out, e_oe, e_pu;
            logic [79:0] e_fsel;
            for (int p = 0; p < NP; p++) begin
                e_out[p*8 +: 8] = m_out[p];
                e_pu[p*8 +: 8]  = has_pull(p) ? m_pull[p] : 8'h0;
                e_fsel[p*16 +: 16] = m_cfg[p];
                for (int i = 0; i < 8; i++)
                    e_oe[p*8+i] = m_dir[p][i] && (m_cfg[p][2*i +: 2] == 2'b00);
            end
            check(rst ? "R1 pin_out" : "R4 R7 R8 pin_out", 128'(pin_out), 128'(e_out));
            check(rst ? "R1 pin_oe" : "R3 pin_oe", 128'(pin_oe), 128'(e_oe));
            check(rst ? "R1 pin_pu" : "R9 pin_pu", 128'(pin_pu), 128'(e_pu));
            check(rst ? "R1 pin_fsel" : "R2 pin_fsel", 128'(pin_fsel), 128'(e_fsel));
            check({m_rd_tag, " bus_rdata"}, 128'(bus_rdata), 128'(m_rd));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(posedge clk);
        started = 1'b1;
        idle(3);                           // R1 reset state compared each cycle
        rst = 1'b0;
        idle(6);                           // R6 snapshot taken with pins held
        for (int p = 0; p < NP; p++) rd(8'h20 + 8'(16*p));
        pin_in = 40'h3C_18_E7_7E_0F;       // R5 new live levels, R6 must not follow
        idle(3);
        for (int p = 0; p < NP; p++) rd(8'h20 + 8'(16*p));
        // R4 direction and output level
        wr(8'h20, 32'hFF_3C_12_34);
        rd(8'h20);
        // R7 set: ones raise, zeros keep
        wr(8'h24, 32'h00_C3_00_00);
        wr(8'h24, 32'h00_00_FF_FF);
        rd(8'h24);
        // R8 clear: ones lower, zeros keep
        wr(8'h28, 32'h00_0F_00_00);
        wr(8'h28, 32'hFF_00_FF_FF);
        rd(8'h28);
        rd(8'h20);
        // R2 R3 function select gates the output enable
        wr(8'h04, 32'hFFFF_0004);
        wr(8'h30, 32'hFF_AA_00_00);
        rd(8'h04);
        wr(8'h04, 32'h0000_C000);
        rd(8'h30);
        wr(8'h10, 32'h0000_5555);
        wr(8'h60, 32'h0F_F0_00_00);
        rd(8'h10);
        // R9 pull-ups, ports 2 and 4 have none
        wr(8'h2C, 32'hFFFF_FFAA);
        wr(8'h4C, 32'h0000_00FF);
        wr(8'h6C, 32'h0000_0033);
        wr(8'h3C, 32'h0000_0081);
        rd(8'h2C); rd(8'h3C); rd(8'h4C); rd(8'h6C);
        // R10 unmapped and unaligned accesses
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h71, 32'hFFFF_FFFF);
        wr(8'h22, 32'hFFFF_FFFF);
        rd(8'h14); rd(8'h70); rd(8'h22); rd(8'h1C);
        // R5 single-cycle pin pulse followed by settle
        @(negedge clk) pin_in = 40'hFF_FF_FF_FF_FF;
        @(negedge clk) pin_in = 40'h00_00_00_00_00;
        rd(8'h20); rd(8'h20); rd(8'h20);
        // R6 fresh reset recaptures the snapshot
        @(negedge clk) begin rst = 1'b1; pin_in = 40'h12_34_56_78_9A; end
        idle(3);
        rst = 1'b0;
        idle(6);
        pin_in = 40'h00_00_00_00_00;
        idle(3);
        for (int p = 0; p < NP; p++) rd(8'h20 + 8'(16*p));
        idle(4);
        finish_run();
    end
endmodule